// File: doc/BRIEF.md
# Configurable 8-bit Register ALU

This block runs the register-to-register arithmetic and logic group of a small 8-bit interpreter-style processor. It owns sixteen 8-bit general registers, numbered 0 to 15. Register 15 also serves as the flag register. Each cycle with `op_valid` high, the block reads the operand registers X and Y, applies the operation picked by the 4-bit `op_sel`, and writes the result to register X. The flag value, where the operation has one, is written to register 15. All of this finishes at a single clock edge.

Two runtime mode inputs change the behaviour:
- `keep_flag_logic` stops the bitwise operations from clearing the flag register.
- `shift_src_x` makes the shifts read register X instead of register Y.

Other instruction groups of the processor place values in the registers through a simple load port. A load takes effect only in a cycle with no operation. The whole register file is visible at all times as one flat output.

A small sequencer records what the previous cycle did, in one of four states:
- ST_IDLE: nothing happened.
- ST_LOAD: a load was written.
- ST_EXEC: a legal operation ran.
- ST_FAULT: an unused operation code was seen.

The state is re-chosen on every clock from that cycle's inputs:
- op_valid with an illegal code goes to ST_FAULT.
- op_valid with a legal code goes to ST_EXEC.
- A load without an operation goes to ST_LOAD.
- Anything else goes to ST_IDLE.
- Reset forces ST_IDLE.

The `illegal_op` output is high exactly while the state is ST_FAULT.

Top module: `quirk_alu`

## Requirements
- R1: Operation 0x0 writes the old value of register Y into register X.
- R2: Operations 0x1, 0x2 and 0x3 write X OR Y, X AND Y and X XOR Y, in that order, into register X.
- R3: When `keep_flag_logic` is 0, operations 0x1 to 0x3 also write 0 into register 15. When it is 1, they leave register 15 unchanged, unless X is 15.
- R4: Operation 0x4 writes (X+Y) mod 256 into register X and writes 1 to register 15 on a carry out, else 0.
- R5: Operation 0x5 writes X−Y and operation 0x7 writes Y−X into register X, both mod 256. In both cases register 15 becomes 1 when the minuend is greater than or equal to the subtrahend, and 0 when a borrow occurs.
- R6: Operation 0x6 writes the source shifted right by one and puts the source's bit 0 in register 15. Operation 0xE writes the source shifted left by one and puts the source's bit 7 in register 15.
- R7: The shift source is register Y when `shift_src_x` is 0 and register X when it is 1. The result always goes to register X.
- R8: When X is 15 and the operation writes a flag, register 15 ends up holding the flag value, not the result.
- R9: Both operands are the values held before the edge, so with X equal to Y each operation uses the original value.
- R10: Codes 0x8 to 0xD and 0xF leave all registers unchanged. They raise `illegal_op` in the cycle after the edge that took them, for one cycle per such operation.
- R11: A synchronous active-high `rst` clears all sixteen registers and `illegal_op`.
- R12: With `ld_en` high and `op_valid` low, `ld_data` is written into register `ld_idx`. With `op_valid` high, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the operation in this cycle |
| op_sel | input | 4 | Operation code |
| idx_x | input | 4 | Destination and first operand register index |
| idx_y | input | 4 | Second operand register index |
| keep_flag_logic | input | 1 | Bitwise operations leave register 15 alone |
| shift_src_x | input | 1 | Shifts read register X instead of Y |
| ld_en | input | 1 | Load request from other instruction groups |
| ld_idx | input | 4 | Load target register |
| ld_data | input | 8 | Load value |
| regs_flat | output | 128 | All registers; register i is bits [8i+7:8i] |
| illegal_op | output | 1 | One-cycle pulse after an unused operation code |

## Verification
On every cycle, the assertions check several behaviours:
- the copy result;
- the flag being cleared or kept by the bitwise operations;
- the addition carry;
- the illegal pulse, with the register file held stable;
- its absence after legal cycles;
- the reset clearing.

The remaining behaviours are shown only by the bench's scenarios, compared against its reference model:
- subtraction borrow in both directions;
- the shift source selection;
- the flag taking precedence over the result when X is 15;
- operations with X equal to Y;
- the load being ignored during an operation.

// File: rtl/quirk_alu_pkg.sv
package quirk_alu_pkg;
    typedef enum logic [3:0] {
        OP_COPY = 4'h0,
        OP_OR   = 4'h1,
        OP_AND  = 4'h2,
        OP_XOR  = 4'h3,
        OP_ADD  = 4'h4,
        OP_SUB  = 4'h5,
        OP_SHR  = 4'h6,
        OP_RSUB = 4'h7,
        OP_SHL  = 4'hE
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/quirk_alu_core.sv
module quirk_alu_core
    import quirk_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_x,
    input  logic [DATA_W-1:0] opnd_y,
    input  logic              keep_flag_logic,
    input  logic              shift_src_x,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              flag_bit,
    output logic              flag_we,
    output logic              bad_code
);
    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] shift_src;

    always_comb begin
        shift_src = shift_src_x ? opnd_x : opnd_y;
    end

    always_comb begin
        wide      = '0;
        result    = '0;
        result_we = 1'b0;
        flag_bit  = 1'b0;
        flag_we   = 1'b0;
        bad_code  = 1'b0;
        unique case (alu_op_e'(op_sel))
            OP_COPY: begin
                result    = opnd_y;
                result_we = 1'b1;
            end
            OP_OR: begin
                result    = opnd_x | opnd_y;
                result_we = 1'b1;
                flag_we   = ~keep_flag_logic;
            end
            OP_AND: begin
                result    = opnd_x & opnd_y;
                result_we = 1'b1;
                flag_we   = ~keep_flag_logic;
            end
            OP_XOR: begin
                result    = opnd_x ^ opnd_y;
                result_we = 1'b1;
                flag_we   = ~keep_flag_logic;
            end
            OP_ADD: begin
                wide      = {1'b0, opnd_x} + {1'b0, opnd_y};
                result    = wide[DATA_W-1:0];
                result_we = 1'b1;
                flag_bit  = wide[DATA_W];
                flag_we   = 1'b1;
            end
            OP_SUB: begin
                wide      = {1'b0, opnd_x} - {1'b0, opnd_y};
                result    = wide[DATA_W-1:0];
                result_we = 1'b1;
                flag_bit  = ~wide[DATA_W];
                flag_we   = 1'b1;
            end
            OP_RSUB: begin
                wide      = {1'b0, opnd_y} - {1'b0, opnd_x};
                result    = wide[DATA_W-1:0];
                result_we = 1'b1;
                flag_bit  = ~wide[DATA_W];
                flag_we   = 1'b1;
            end
            OP_SHR: begin
                result    = shift_src >> 1;
                result_we = 1'b1;
                flag_bit  = shift_src[0];
                flag_we   = 1'b1;
            end
            OP_SHL: begin
                result    = shift_src << 1;
                result_we = 1'b1;
                flag_bit  = shift_src[DATA_W-1];
                flag_we   = 1'b1;
            end
            default: begin
                bad_code = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/quirk_alu_regs.sv
module quirk_alu_regs #(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       rd_x_idx,
    input  logic [IDX_W-1:0]       rd_y_idx,
    output logic [DATA_W-1:0]      rd_x_val,
    output logic [DATA_W-1:0]      rd_y_val,
    input  logic                   res_we,
    input  logic [IDX_W-1:0]       res_idx,
    input  logic [DATA_W-1:0]      res_val,
    input  logic                   flg_we,
    input  logic                   flg_val,
    input  logic                   ld_we,
    input  logic [IDX_W-1:0]       ld_idx,
    input  logic [DATA_W-1:0]      ld_val,
    output logic [NREG*DATA_W-1:0] flat
);
    localparam int FLAG_IDX = NREG - 1;

    logic [DATA_W-1:0] bank [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
        logic is_flag_reg;
        assign is_flag_reg = (gi == FLAG_IDX);

        always_ff @(posedge clk) begin
            if (rst) begin
                bank[gi] <= '0;
            end else if (flg_we && is_flag_reg) begin
                bank[gi] <= {{(DATA_W-1){1'b0}}, flg_val};
            end else if (res_we && res_idx == MY_IDX) begin
                bank[gi] <= res_val;
            end else if (ld_we && ld_idx == MY_IDX) begin
                bank[gi] <= ld_val;
            end
        end

        assign flat[gi*DATA_W +: DATA_W] = bank[gi];
    end

    always_comb begin
        rd_x_val = bank[rd_x_idx];
        rd_y_val = bank[rd_y_idx];
    end
endmodule

// File: rtl/quirk_alu.sv
module quirk_alu
    import quirk_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic [3:0]             op_sel,
    input  logic [IDX_W-1:0]       idx_x,
    input  logic [IDX_W-1:0]       idx_y,
    input  logic                   keep_flag_logic,
    input  logic                   shift_src_x,
    input  logic                   ld_en,
    input  logic [IDX_W-1:0]       ld_idx,
    input  logic [DATA_W-1:0]      ld_data,
    output logic [NREG*DATA_W-1:0] regs_flat,
    output logic                   illegal_op
);
    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] vx, vy, core_res;
    logic              core_res_we, core_flag, core_flag_we, core_bad;
    logic              commit_res, commit_flag, commit_load;

    quirk_alu_core #(.DATA_W(DATA_W)) u_core (
        .op_sel          (op_sel),
        .opnd_x          (vx),
        .opnd_y          (vy),
        .keep_flag_logic (keep_flag_logic),
        .shift_src_x     (shift_src_x),
        .result          (core_res),
        .result_we       (core_res_we),
        .flag_bit        (core_flag),
        .flag_we         (core_flag_we),
        .bad_code        (core_bad)
    );

    always_comb begin
        commit_res  = op_valid && core_res_we && !core_bad;
        commit_flag = op_valid && core_flag_we && !core_bad;
        commit_load = ld_en && !op_valid;
    end

    quirk_alu_regs #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_x_idx (idx_x),
        .rd_y_idx (idx_y),
        .rd_x_val (vx),
        .rd_y_val (vy),
        .res_we   (commit_res),
        .res_idx  (idx_x),
        .res_val  (core_res),
        .flg_we   (commit_flag),
        .flg_val  (core_flag),
        .ld_we    (commit_load),
        .ld_idx   (ld_idx),
        .ld_val   (ld_data),
        .flat     (regs_flat)
    );

    always_comb begin
        if (op_valid && core_bad)      state_d = ST_FAULT;
        else if (op_valid)             state_d = ST_EXEC;
        else if (ld_en)                state_d = ST_LOAD;
        else                           state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_FAULT: illegal_op = 1'b1;
            ST_IDLE,
            ST_LOAD,
            ST_EXEC:  illegal_op = 1'b0;
            default:  illegal_op = 1'b0;
        endcase
    end
endmodule

// File: rtl/quirk_alu_chk.sv
module quirk_alu_chk #(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   op_valid,
    input logic [3:0]             op_sel,
    input logic [IDX_W-1:0]       idx_x,
    input logic [IDX_W-1:0]       idx_y,
    input logic                   keep_flag_logic,
    input logic [NREG*DATA_W-1:0] regs_flat,
    input logic                   illegal_op
);
    localparam logic [IDX_W-1:0] FIDX = IDX_W'(NREG - 1);

    function automatic logic [DATA_W-1:0] pick(input logic [NREG*DATA_W-1:0] f,
                                               input logic [IDX_W-1:0] i);
        return f[int'(i)*DATA_W +: DATA_W];
    endfunction

    logic [DATA_W-1:0] cur_x, cur_y, cur_f;
    logic [DATA_W:0]   sum_w;
    logic              bad_now, logic_now;

    always_comb begin
        cur_x     = pick(regs_flat, idx_x);
        cur_y     = pick(regs_flat, idx_y);
        cur_f     = pick(regs_flat, FIDX);
        sum_w     = {1'b0, cur_x} + {1'b0, cur_y};
        bad_now   = (op_sel >= 4'h8) && (op_sel != 4'hE);
        logic_now = (op_sel == 4'h1) || (op_sel == 4'h2) || (op_sel == 4'h3);
    end

    p_copy_r1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 4'h0 && idx_x != FIDX)
        |=> pick(regs_flat, $past(idx_x)) == $past(cur_y));

    p_logic_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && logic_now && !keep_flag_logic) |=> cur_f == '0);

    p_logic_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && logic_now && keep_flag_logic && idx_x != FIDX)
        |=> cur_f == $past(cur_f));

    p_add_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 4'h4)
        |=> cur_f == {{(DATA_W-1){1'b0}}, $past(sum_w[DATA_W])});

    p_illegal_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && bad_now) |=> (illegal_op && $stable(regs_flat)));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && bad_now) |=> !illegal_op);

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (regs_flat == '0 && !illegal_op));
endmodule

bind quirk_alu quirk_alu_chk #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .op_valid        (op_valid),
    .op_sel          (op_sel),
    .idx_x           (idx_x),
    .idx_y           (idx_y),
    .keep_flag_logic (keep_flag_logic),
    .regs_flat       (regs_flat),
    .illegal_op      (illegal_op)
);

// File: tb/quirk_alu_tb.sv
module quirk_alu_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [3:0]   op_sel = '0;
    logic [3:0]   idx_x = '0;
    logic [3:0]   idx_y = '0;
    logic         keep_flag_logic = 1'b0;
    logic         shift_src_x = 1'b0;
    logic         ld_en = 1'b0;
    logic [3:0]   ld_idx = '0;
    logic [7:0]   ld_data = '0;
    logic [127:0] regs_flat;
    logic         illegal_op;

    int errors = 0;
    int checks = 0;
    int mref [16];

    always #2 clk = ~clk;

    quirk_alu u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .idx_x(idx_x), .idx_y(idx_y), .keep_flag_logic(keep_flag_logic),
        .shift_src_x(shift_src_x), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .regs_flat(regs_flat), .illegal_op(illegal_op)
    );

    function automatic logic [127:0] model_flat();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(mref[i]);
        return v;
    endfunction

    function automatic bit is_bad(input int op);
        return (op >= 8) && (op != 14);
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1, 2, 3: return "R2";
            4: return "R4";
            5, 7: return "R5";
            6, 14: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input int op, input int x, input int y,
                        input bit kf, input bit sx, input bit ld, input int li,
                        input int ldv, input string req);
        bit exp_ill;
        @(negedge clk);
        op_valid = v; op_sel = 4'(op); idx_x = 4'(x); idx_y = 4'(y);
        keep_flag_logic = kf; shift_src_x = sx;
        ld_en = ld; ld_idx = 4'(li); ld_data = 8'(ldv);
        exp_ill = v && is_bad(op);
        if (v && !is_bad(op)) begin
            int a, b, src, r, f;
            bit wf;
            a = mref[x]; b = mref[y]; src = sx ? a : b;
            r = 0; f = 0; wf = 1'b1;
            case (op)
                0: begin r = b; wf = 1'b0; end
                1: begin r = a | b; wf = !kf; end
                2: begin r = a & b; wf = !kf; end
                3: begin r = a ^ b; wf = !kf; end
                4: begin r = (a + b) % 256; f = (a + b > 255) ? 1 : 0; end
                5: begin r = (a - b + 256) % 256; f = (a >= b) ? 1 : 0; end
                7: begin r = (b - a + 256) % 256; f = (b >= a) ? 1 : 0; end
                6: begin r = src / 2; f = src % 2; end
                default: begin r = (src * 2) % 256; f = src / 128; end
            endcase
            mref[x] = r;
            if (wf) mref[15] = f;
        end else if (!v && ld) begin
            mref[li] = ldv;
        end
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; ld_en = 1'b0;
        check(req, regs_flat, model_flat());
        check(exp_ill ? "R10 pulse" : "R10 quiet", {127'd0, illegal_op}, {127'd0, exp_ill});
    endtask

    task automatic load(input int r, input int val);
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b1, r, val, "R12");
    endtask

    task automatic op(input int o, input int x, input int y, input bit kf, input bit sx,
                      input string req);
        step(1'b1, o, x, y, kf, sx, 1'b0, 0, 0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mref[i] = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset", regs_flat, '0);
        check("R11 reset", {127'd0, illegal_op}, '0);

        // R12 loads
        for (int i = 0; i < 16; i++) load(i, (i * 37 + 11) % 256);
        load(1, 200); load(2, 100); load(3, 8'h81); load(4, 8'h3C);

        op(0, 5, 1, 0, 0, "R1 copy");
        op(1, 6, 3, 0, 0, "R2 or, R3 clear");
        load(15, 8'h55);
        op(2, 7, 4, 1, 0, "R2 and, R3 keep");
        op(3, 8, 4, 1, 0, "R2 xor, R3 keep");
        op(3, 9, 9, 0, 0, "R2 xor self, R3 clear, R9");
        op(4, 1, 2, 0, 0, "R4 add carry");
        op(4, 4, 4, 0, 0, "R4 add no carry, R9");
        load(10, 5); load(11, 9);
        op(5, 10, 11, 0, 0, "R5 sub borrow");
        load(10, 9); load(11, 9);
        op(5, 10, 11, 0, 0, "R5 sub equal no borrow");
        load(10, 3); load(11, 9);
        op(7, 10, 11, 0, 0, "R5 rsub no borrow");
        op(7, 11, 10, 0, 0, "R5 rsub borrow");
        load(12, 8'h02); load(13, 8'h81);
        op(6, 12, 13, 0, 0, "R6 shr, R7 from y");
        load(12, 8'h02);
        op(6, 12, 13, 0, 1, "R6 shr, R7 from x");
        load(12, 8'h40);
        op(14, 12, 13, 0, 0, "R6 shl, R7 from y");
        load(12, 8'hC0);
        op(14, 12, 13, 0, 1, "R6 shl, R7 from x");
        // R8: X = 15, flag beats result
        load(15, 8'h10); load(1, 8'hFF);
        op(4, 15, 1, 0, 0, "R8 add into flag reg");
        check("R8 literal", {120'd0, regs_flat[127:120]}, 128'd1);
        load(15, 8'hF0);
        op(5, 15, 15, 0, 0, "R8 sub self into flag reg, R9");
        check("R8 literal", {120'd0, regs_flat[127:120]}, 128'd1);
        load(15, 8'h0F); load(2, 8'hF0);
        op(1, 15, 2, 1, 0, "R8 or keep with X=15 writes result");
        // R10 illegal codes
        for (int c = 8; c < 16; c++) begin
            if (c != 14) op(c, 3, 4, 0, 0, "R10 illegal");
        end
        // R12 load ignored while an op runs
        step(1'b1, 0, 5, 6, 0, 0, 1'b1, 5, 8'hAA, "R12 load ignored");
        step(1'b1, 9, 5, 6, 0, 0, 1'b1, 7, 8'hAA, "R12 load ignored with illegal");
        // mixed stream
        for (int k = 0; k < 400; k++) begin
            int o;
            o = int'($urandom_range(0, 15));
            if ($urandom_range(0, 4) == 0)
                load(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
            else
                op(o, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), tag_of(o));
        end
        // R11 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) mref[i] = 0;
        check("R11 reset again", regs_flat, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule